// File: doc/BRIEF.md
# Software-Refilled Translation Cache with Lockable Entries

This block is a small, fully associative cache of translations from virtual page numbers to physical frame numbers. It sits beside a processor's memory pipeline. It does not walk any page tables. When a lookup finds no valid entry, the block raises a miss trap. The trap handler then computes the mapping and installs it through a fill port. Each lookup ends in one of three outcomes in the same cycle: a hit that returns the frame and the permission bits, a miss trap, or a protection fault.

Software manages the contents through three control inputs. A fill installs one translation. A lock operation pins an entry so that replacement and flush both leave it alone. A flush, issued on a context switch, drops every entry that is not locked. The next victim is picked by a round-robin pointer that skips locked entries. A fill that finds every entry locked is refused, and an error flag reports the refusal.

Top module: `soft_tlb`

## Requirements
- R1: After reset, no entry is valid, every lookup reports a miss, and the replacement pointer sits at entry 0.
- R2: A lookup of address {vpn, offset} that matches a valid entry and whose access is permitted raises hit in the same cycle, drives paddr = {pfn, offset}, and drives the entry's permission bits on lk_perm.
- R3: A lookup that matches no valid entry raises miss, keeps hit and fault low, and drives paddr and lk_perm to zero.
- R4: A lock request (lock_en, with lock_set = 1 to lock and 0 to unlock) changes the lock bit of the valid entry whose page equals lock_vpn at the next edge. A locked entry is never chosen as a victim. A lock bit is cleared only by an unlock request.
- R5: A fill whose page matches a valid entry overwrites that entry in place. The new lock bit is the old lock bit OR fill_lock. No duplicate entry is created, and the replacement pointer does not move.
- R6: A flush invalidates every unlocked entry at the next edge and leaves locked entries valid and unchanged.
- R7: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. lk_acc uses 0 for read, 1 for write and 2 for execute; the value 3 is never permitted. A matching lookup whose access is not permitted raises fault, keeps hit low and paddr at zero, and still drives lk_perm.
- R8: At most one of hit, miss and fault is high in any cycle.
- R9: While lk_valid is low, hit, miss and fault are all low.
- R10: A fill of a new page while every entry is locked raises fill_err in the same cycle and leaves every entry unchanged.
- R11: A fill of a new page writes the first unlocked entry at or after the replacement pointer, searching circularly. The pointer then moves to the entry after the one written.
- R12: In a cycle where flush_en is high, any fill or lock request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | Miss trap, no valid entry matched |
| lk_fault | output | 1 | Protection fault on a matching entry |
| lk_paddr | output | 32 | Physical address on a hit, otherwise zero |
| lk_perm | output | 3 | Permission bits of the matching entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_perm | input | 3 | Permission bits to install |
| fill_lock | input | 1 | Install the entry already locked |
| fill_err | output | 1 | Fill refused because every entry is locked |
| lock_en | input | 1 | Lock or unlock request |
| lock_vpn | input | 20 | Page whose entry is locked or unlocked |
| lock_set | input | 1 | 1 locks, 0 unlocks |
| flush_en | input | 1 | Invalidate every unlocked entry |

## Verification
A corrupted valid or page field becomes visible on the first lookup of that page. It shows as a wrong miss, a wrong hit, or a frame from another entry, all in the same cycle as the lookup. A wrong replacement pointer or a wrong lock bit stays hidden until a later fill chooses its victim. It then surfaces on the following lookup as an eviction of the wrong page. The bench therefore steps through fill sequences whose victim is known in advance, and probes both the survivors and the evicted pages right after each step. A lost lock bit surfaces only after a flush or an all-locked fill, so both of those cases are driven with pinned entries in place.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W = 20;
    parameter int PFN_W = 20;
    parameter int OFS_W = 12;
    parameter int VA_W  = VPN_W + OFS_W;
    parameter int PA_W  = PFN_W + OFS_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    // bit0 read, bit1 write, bit2 execute
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic  valid;
        logic  locked;
        vpn_t  vpn;
        pfn_t  pfn;
        perm_t perm;
    } entry_t;

    function automatic logic perm_allows(perm_t p, acc_e a);
        case (a)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  entry_t [N-1:0] ents,
    input  vpn_t           key,
    output logic [N-1:0]   hitv,
    output logic           any,
    output logic [IW-1:0]  idx
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hitv[i] = ents[i].valid && (ents[i].vpn == key);
    end

    assign any = |hitv;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hitv[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  locked,
    input  logic [IW-1:0] start,
    output logic [IW-1:0] idx,
    output logic          none_free
);
    always_comb begin
        int  j;
        logic found;
        j     = 0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            j = (int'(start) + k) % N;
            if (!found && !locked[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
        none_free = !found;
    end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  entry_t         wr_entry,
    input  logic           lk_en,
    input  logic [IW-1:0]  lk_idx,
    input  logic           lk_val,
    output entry_t [N-1:0] ents
);
    entry_t mem [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (flush) begin
                if (!mem[i].locked) mem[i].valid <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IW'(i)) mem[i] <= wr_entry;
                if (lk_en && lk_idx == IW'(i)) mem[i].locked <= lk_val;
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign ents[i] = mem[i];
    end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    output logic [2:0]       lk_perm,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [2:0]       fill_perm,
    input  logic             fill_lock,
    output logic             fill_err,
    input  logic             lock_en,
    input  logic [VPN_W-1:0] lock_vpn,
    input  logic             lock_set,
    input  logic             flush_en
);
    entry_t [N_ENTRIES-1:0] ents;
    logic   [N_ENTRIES-1:0] valid_v, lock_v;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_flags
        assign valid_v[i] = ents[i].valid;
        assign lock_v[i]  = ents[i].locked;
    end

    // lookup side
    logic [N_ENTRIES-1:0] lk_hitv;
    logic                 lk_any;
    logic [IW-1:0]        lk_idx;
    vpn_t                 lk_vpn;
    entry_t               lk_sel;
    logic                 lk_ok;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

    tlb_match #(.N(N_ENTRIES)) u_lk_match (
        .ents(ents), .key(lk_vpn), .hitv(lk_hitv), .any(lk_any), .idx(lk_idx)
    );

    assign lk_sel   = ents[lk_idx];
    assign lk_ok    = perm_allows(lk_sel.perm, acc_e'(lk_acc));
    assign lk_hit   = lk_valid && lk_any && lk_ok;
    assign lk_fault = lk_valid && lk_any && !lk_ok;
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_paddr = lk_hit ? {lk_sel.pfn, lk_vaddr[OFS_W-1:0]} : '0;
    assign lk_perm  = (lk_valid && lk_any) ? lk_sel.perm : 3'b000;

    // fill side
    logic [N_ENTRIES-1:0] f_hitv;
    logic                 f_any;
    logic [IW-1:0]        f_idx;
    logic [IW-1:0]        vic_idx;
    logic                 none_free;
    logic [IW-1:0]        rr_q;
    logic                 fill_go, fill_new, wr_en;
    logic [IW-1:0]        wr_idx;
    entry_t               wr_entry;

    tlb_match #(.N(N_ENTRIES)) u_fill_match (
        .ents(ents), .key(fill_vpn), .hitv(f_hitv), .any(f_any), .idx(f_idx)
    );

    tlb_victim #(.N(N_ENTRIES)) u_victim (
        .locked(lock_v), .start(rr_q), .idx(vic_idx), .none_free(none_free)
    );

    assign fill_go  = fill_en && !flush_en;
    assign fill_new = fill_go && !f_any && !none_free;
    assign fill_err = fill_go && !f_any && none_free;
    assign wr_en    = fill_go && (f_any || !none_free);
    assign wr_idx   = f_any ? f_idx : vic_idx;

    always_comb begin
        wr_entry        = '0;
        wr_entry.valid  = 1'b1;
        wr_entry.locked = fill_lock || (f_any && ents[f_idx].locked);
        wr_entry.vpn    = fill_vpn;
        wr_entry.pfn    = fill_pfn;
        wr_entry.perm   = perm_t'(fill_perm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill_new) begin
            rr_q <= (vic_idx == IW'(N_ENTRIES - 1)) ? '0 : vic_idx + 1'b1;
        end
    end

    // lock side
    logic [N_ENTRIES-1:0] l_hitv;
    logic                 l_any;
    logic [IW-1:0]        l_idx;

    tlb_match #(.N(N_ENTRIES)) u_lock_match (
        .ents(ents), .key(lock_vpn), .hitv(l_hitv), .any(l_any), .idx(l_idx)
    );

    tlb_array #(.N(N_ENTRIES)) u_array (
        .clk(clk), .rst(rst), .flush(flush_en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .lk_en(lock_en && !flush_en && l_any), .lk_idx(l_idx), .lk_val(lock_set),
        .ents(ents)
    );
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic [1:0]   lk_acc,
    input logic         lk_hit,
    input logic         lk_miss,
    input logic         lk_fault,
    input logic [2:0]   lk_perm,
    input logic         flush_en,
    input logic         lock_en,
    input logic         fill_err,
    input logic [N-1:0] valid_v,
    input logic [N-1:0] lock_v,
    input logic [N-1:0] lk_match_v
);
    // R8
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    // R6
    flush_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flush_en)) |-> (valid_v == $past(valid_v & lock_v)));

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(lock_en)) |-> (($past(lock_v) & ~lock_v) == '0));

    // R5
    no_dup_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match_v));

    // R7
    perm_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_acc == 2'd1) |-> lk_perm[1]);

    // R10
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_err && !lock_en && !flush_en) |=> $stable(valid_v));
endmodule

bind soft_tlb tlb_chk #(.N(N_ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_perm(lk_perm),
    .flush_en(flush_en), .lock_en(lock_en), .fill_err(fill_err),
    .valid_v(valid_v), .lock_v(lock_v), .lk_match_v(lk_hitv)
);

// File: tb/soft_tlb_test.sv
module soft_tlb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_perm;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_perm = '0;
    logic        fill_lock = 1'b0;
    logic        fill_err;
    logic        lock_en = 1'b0;
    logic [19:0] lock_vpn = '0;
    logic        lock_set = 1'b0;
    logic        flush_en = 1'b0;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    soft_tlb uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] acc);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_acc   = acc;
        #1;
    endtask

    task automatic want_hit(input string req, input logic [19:0] vpn, input logic [19:0] pfn,
                            input logic [1:0] acc);
        look(vpn, 12'h3a5, acc);
        chk({req, " hit/miss/fault"}, {lk_hit, lk_miss, lk_fault}, 3'b100);
        chk({req, " paddr"}, lk_paddr, {pfn, 12'h3a5});
    endtask

    task automatic want_miss(input string req, input logic [19:0] vpn);
        look(vpn, 12'h010, 2'd0);
        chk({req, " miss"}, {lk_hit, lk_miss, lk_fault, lk_paddr, lk_perm}, {3'b010, 32'h0, 3'b000});
    endtask

    task automatic want_fault(input string req, input logic [19:0] vpn, input logic [1:0] acc,
                              input logic [2:0] perm);
        look(vpn, 12'h777, acc);
        chk({req, " fault"}, {lk_hit, lk_miss, lk_fault, lk_paddr, lk_perm}, {3'b001, 32'h0, perm});
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm,
                           input logic lk, input logic fl, output logic err);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm; fill_lock = lk;
        flush_en = fl;
        #1 err = fill_err;
        @(posedge clk);
        #1 fill_en = 1'b0; fill_lock = 1'b0; flush_en = 1'b0;
    endtask

    task automatic do_lock(input logic [19:0] vpn, input logic set);
        @(negedge clk);
        lock_en = 1'b1; lock_vpn = vpn; lock_set = set;
        @(posedge clk);
        #1 lock_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_en = 1'b1;
        @(posedge clk);
        #1 flush_en = 1'b0;
    endtask

    task automatic t_reset();
        want_miss("R1 reset", 20'h12345);
        want_miss("R1 reset", 20'h00000);
    endtask

    task automatic t_basic();
        logic e;
        do_fill(20'h00010, 20'h0abcd, 3'b001, 1'b0, 1'b0, e);
        chk("R10 no error on free fill", e, 1'b0);
        want_hit("R2 read", 20'h00010, 20'h0abcd, 2'd0);
        chk("R2 perm out", lk_perm, 3'b001);
        want_fault("R7 write on read-only", 20'h00010, 2'd1, 3'b001);
        want_fault("R7 exec on read-only", 20'h00010, 2'd2, 3'b001);
        want_miss("R3 other page", 20'h00011);
    endtask

    task automatic t_overwrite();
        logic e;
        do_fill(20'h00010, 20'h0beef, 3'b011, 1'b0, 1'b0, e);
        want_hit("R5 overwritten frame", 20'h00010, 20'h0beef, 2'd1);
        want_fault("R7 reserved access", 20'h00010, 2'd3, 3'b011);
    endtask

    task automatic t_round_robin();
        logic e;
        for (int i = 0; i < 7; i++)
            do_fill(20'h00100 + 20'(i), 20'h01000 + 20'(i), 3'b111, 1'b0, 1'b0, e);
        want_hit("R5 no duplicate consumed slot", 20'h00010, 20'h0beef, 2'd0);
        do_fill(20'h00200, 20'h02000, 3'b101, 1'b0, 1'b0, e);
        want_miss("R11 wrap evicts entry 0", 20'h00010);
        want_hit("R11 neighbour kept", 20'h00100, 20'h01000, 2'd2);
        want_hit("R11 new entry", 20'h00200, 20'h02000, 2'd2);
    endtask

    task automatic t_lock_skip();
        logic e;
        do_lock(20'h00100, 1'b1);
        do_fill(20'h00201, 20'h02001, 3'b001, 1'b0, 1'b0, e);
        want_hit("R4 locked entry skipped", 20'h00100, 20'h01000, 2'd0);
        want_miss("R11 next unlocked evicted", 20'h00101);
        want_hit("R11 placed", 20'h00201, 20'h02001, 2'd0);
    endtask

    task automatic t_flush();
        do_flush();
        want_hit("R6 locked survives", 20'h00100, 20'h01000, 2'd1);
        want_miss("R6 unlocked dropped", 20'h00200);
        want_miss("R6 unlocked dropped", 20'h00201);
    endtask

    task automatic t_all_locked();
        logic e;
        for (int i = 0; i < 7; i++) begin
            do_fill(20'h00300 + 20'(i), 20'h03000 + 20'(i), 3'b001, 1'b1, 1'b0, e);
            chk("R10 fill accepted", e, 1'b0);
        end
        do_fill(20'h00400, 20'h04000, 3'b001, 1'b0, 1'b0, e);
        chk("R10 all locked error", e, 1'b1);
        want_miss("R10 rejected page absent", 20'h00400);
        want_hit("R10 entries unchanged", 20'h00306, 20'h03006, 2'd0);
        want_hit("R10 entries unchanged", 20'h00100, 20'h01000, 2'd0);
        do_fill(20'h00300, 20'h03333, 3'b011, 1'b0, 1'b0, e);
        chk("R5 overwrite allowed when full", e, 1'b0);
        want_hit("R5 overwrite when full", 20'h00300, 20'h03333, 2'd1);
    endtask

    task automatic t_unlock();
        logic e;
        do_lock(20'h00300, 1'b0);
        do_fill(20'h00401, 20'h04001, 3'b001, 1'b0, 1'b0, e);
        chk("R4 unlock frees slot", e, 1'b0);
        want_miss("R4 unlocked entry replaced", 20'h00300);
        want_hit("R4 fill landed", 20'h00401, 20'h04001, 2'd0);
    endtask

    task automatic t_flush_priority();
        logic e;
        do_fill(20'h00500, 20'h05000, 3'b001, 1'b0, 1'b1, e);
        chk("R12 no error during flush", e, 1'b0);
        want_miss("R12 fill ignored", 20'h00500);
        want_miss("R6 unlocked cleared", 20'h00401);
        want_hit("R6 locked kept", 20'h00301, 20'h03001, 2'd0);
        @(negedge clk);
        lock_en = 1'b1; lock_vpn = 20'h00301; lock_set = 1'b0; flush_en = 1'b1;
        @(posedge clk);
        #1 lock_en = 1'b0; flush_en = 1'b0;
        do_flush();
        want_hit("R12 unlock ignored", 20'h00301, 20'h03001, 2'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        lk_valid = 1'b0;
        lk_vaddr = {20'h00100, 12'h0};
        #1;
        chk("R9 idle outputs", {lk_hit, lk_miss, lk_fault}, 3'b000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_overwrite();
        t_round_robin();
        t_lock_skip();
        t_flush();
        t_all_locked();
        t_unlock();
        t_flush_priority();
        t_idle();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule